// File: doc/BRIEF.md
# First-Arrival Pulse Capture Arbiter

This block watches a vector of request lines and records which one asserted first. Every rising clock edge in the idle state samples all request lines. The first edge that finds any line high moves the block into its locked state and loads that line's index into an ID register. A pulse that is high for only one clock cycle is enough. Once locked, the block ignores the request vector completely. Only the synchronous reset brings it back to idle.

Two or more lines can be first seen high at the same edge. In that case the line with the highest index wins. A request that is high at the same edge as the reset is not recorded. Sampling starts at the first edge after the reset is released.

The control has two states, `ST_IDLE` and `ST_CAPTURED`, with these transitions:
- IDLE_WAIT: `ST_IDLE` to `ST_IDLE` when no request is seen.
- IDLE_GRAB: `ST_IDLE` to `ST_CAPTURED` when at least one request is seen.
- CAP_HOLD: `ST_CAPTURED` to `ST_CAPTURED` whatever the requests are.
- RESET_CLEAR: any state to `ST_IDLE` when `srst` is high. This transition wins over the other three.

Top module: `first_arrival_arbiter`

## Requirements
- R1: On a rising edge with `srst` high, the block enters `ST_IDLE`. After that edge, `captured` is 0 and `cap_id` is 0.
- R2: In `ST_IDLE`, an edge that sees `req` all zero leaves `captured` at 0.
- R3: In `ST_IDLE`, an edge that sees exactly one request bit k high sets `captured` to 1 and `cap_id` to k (unsigned binary index, bit 0 = index 0), visible after that edge.
- R4: A request bit that is high for a single clock cycle, across one rising edge, is captured exactly as in R3.
- R5: When several bits of `req` are high at the capturing edge, `cap_id` takes the highest set index.
- R6: In `ST_CAPTURED`, `captured` stays 1 and `cap_id` stays unchanged whatever `req` does, until `srst`.
- R7: Only `srst` leaves `ST_CAPTURED`. After the reset, a new request is captured as in R3.
- R8: Requests that are high at an edge where `srst` is high are not captured. The next edge with `srst` low is the first to sample.
- R9: While `captured` is 0, `cap_id` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| srst | input | 1 | Synchronous reset/clear, active high |
| req | input | NUM_REQ | Request lines, active high, one bit per requester |
| captured | output | 1 | High while in `ST_CAPTURED` |
| cap_id | output | ID_W | Index of the captured request; 0 while idle |

## Verification
On every cycle, the assertions check these behaviours:
- the IDLE_WAIT and IDLE_GRAB transitions;
- the lock in `ST_CAPTURED`, with a steady `cap_id` (R6);
- the zero ID while idle (R9);
- the rule that the captured index is the highest bit set at the capturing edge.

Some behaviours involve the reset edge, which the clocked properties disable. These are the clearing itself, the rejection of requests that coincide with reset, and the fresh capture after a clear. Only the bench's scenarios show them, by comparing the outputs with a behavioural model on every clock.

// File: rtl/fa_arb_pkg.sv
package fa_arb_pkg;
    typedef enum logic {
        ST_IDLE     = 1'b0,
        ST_CAPTURED = 1'b1
    } arb_state_t;
endpackage

// File: rtl/fa_pick.sv
// Highest-index selector for requests seen in the same cycle.
module fa_pick #(
    parameter int NUM_REQ = 8,
    localparam int ID_W = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
    input  logic [NUM_REQ-1:0] req,
    output logic               any_req,
    output logic [ID_W-1:0]    win_id
);
    logic [NUM_REQ:0]   above_hit;
    logic [NUM_REQ-1:0] win_onehot;

    assign above_hit[NUM_REQ] = 1'b0;

    for (genvar i = NUM_REQ - 1; i >= 0; i--) begin : g_chain
        assign above_hit[i]  = above_hit[i+1] | req[i];
        assign win_onehot[i] = req[i] & ~above_hit[i+1];
    end

    assign any_req = above_hit[0];

    always_comb begin
        win_id = '0;
        for (int i = 0; i < NUM_REQ; i++) begin
            if (win_onehot[i]) begin
                win_id = win_id | ID_W'(i);
            end
        end
    end
endmodule

// File: rtl/fa_ctrl.sv
// Two-state control: idle sampling, then locked after the first request.
module fa_ctrl
    import fa_arb_pkg::*;
(
    input  logic clk,
    input  logic srst,
    input  logic any_req,
    output logic load_id,
    output logic locked
);
    arb_state_t state_q, state_d;

    // State register
    always_ff @(posedge clk) begin
        if (srst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (any_req) state_d = ST_CAPTURED;
            ST_CAPTURED: state_d = ST_CAPTURED;
            default:     state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        load_id = 1'b0;
        locked  = 1'b0;
        unique case (state_q)
            ST_IDLE:     load_id = any_req;
            ST_CAPTURED: locked  = 1'b1;
            default:     begin end
        endcase
    end
endmodule

// File: rtl/fa_id_reg.sv
// Index register: cleared by reset, loaded once on capture.
module fa_id_reg #(
    parameter int ID_W = 3
) (
    input  logic            clk,
    input  logic            srst,
    input  logic            load,
    input  logic [ID_W-1:0] din,
    output logic [ID_W-1:0] dout
);
    always_ff @(posedge clk) begin
        if (srst) begin
            dout <= '0;
        end else if (load) begin
            dout <= din;
        end
    end
endmodule

// File: rtl/first_arrival_arbiter.sv
module first_arrival_arbiter #(
    parameter int NUM_REQ = 8,
    localparam int ID_W = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
    input  logic               clk,
    input  logic               srst,
    input  logic [NUM_REQ-1:0] req,
    output logic               captured,
    output logic [ID_W-1:0]    cap_id
);
    logic            any_req;
    logic            load_id;
    logic [ID_W-1:0] win_id;

    fa_pick #(.NUM_REQ(NUM_REQ)) u_pick (
        .req     (req),
        .any_req (any_req),
        .win_id  (win_id)
    );

    fa_ctrl u_ctrl (
        .clk     (clk),
        .srst    (srst),
        .any_req (any_req),
        .load_id (load_id),
        .locked  (captured)
    );

    fa_id_reg #(.ID_W(ID_W)) u_id (
        .clk  (clk),
        .srst (srst),
        .load (load_id),
        .din  (win_id),
        .dout (cap_id)
    );
endmodule

// File: rtl/fa_arb_chk.sv
module fa_arb_chk #(
    parameter int NUM_REQ = 8,
    localparam int ID_W = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
    input logic               clk,
    input logic               srst,
    input logic [NUM_REQ-1:0] req,
    input logic               captured,
    input logic [ID_W-1:0]    cap_id
);
    // R2
    stay_idle_chk: assert property (@(posedge clk) disable iff (srst)
        (!captured && req == '0) |=> !captured);

    // R3
    grab_chk: assert property (@(posedge clk) disable iff (srst)
        (!captured && req != '0) |=> captured);

    // R5
    highest_wins_chk: assert property (@(posedge clk) disable iff (srst)
        (!captured && req != '0) |=> (($past(req) >> cap_id) == NUM_REQ'(1)));

    // R6
    hold_lock_chk: assert property (@(posedge clk) disable iff (srst)
        captured |=> (captured && $stable(cap_id)));

    // R9
    idle_zero_chk: assert property (@(posedge clk) disable iff (srst)
        !captured |-> cap_id == '0);
endmodule

bind first_arrival_arbiter fa_arb_chk #(.NUM_REQ(NUM_REQ)) u_chk (
    .clk      (clk),
    .srst     (srst),
    .req      (req),
    .captured (captured),
    .cap_id   (cap_id)
);

// File: tb/first_arrival_arbiter_bench.sv
module first_arrival_arbiter_bench;
    localparam int N = 8;

    logic         clk = 1'b0;
    logic         srst = 1'b1;
    logic [N-1:0] req = '0;
    logic         captured;
    logic [2:0]   cap_id;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  done     = 1'b0;
    bit  m_cap    = 1'b0;
    int  m_id     = 0;

    always #10 clk = ~clk;

    first_arrival_arbiter #(.NUM_REQ(N)) u_first_arrival_arbiter (
        .clk      (clk),
        .srst     (srst),
        .req      (req),
        .captured (captured),
        .cap_id   (cap_id)
    );

    task automatic finish_run();
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    // Drive at the falling edge, update the model at the rising edge, compare at the next falling edge.
    task automatic step(input bit r, input logic [N-1:0] q, input string tag);
        srst = r;
        req  = q;
        @(posedge clk);
        if (r) begin
            m_cap = 1'b0;
            m_id  = 0;
        end else if (!m_cap && q != '0) begin
            m_cap = 1'b1;
            for (int i = 0; i < N; i++) begin
                if (q[i]) m_id = i;
            end
        end
        @(negedge clk);
        n_checks++;
        if (captured !== m_cap || int'(cap_id) != m_id) begin
            n_fail++;
            $display("FAIL %s: captured=%0b cap_id=%0d expected captured=%0b cap_id=%0d",
                     tag, captured, cap_id, m_cap, m_id);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not end, expected completion");
            finish_run();
        end
    end

    initial begin
        @(negedge clk);
        step(1'b1, '0, "R1");
        step(1'b1, '0, "R1");
        for (int k = 0; k < 3; k++) step(1'b0, '0, "R2");
        step(1'b0, '0, "R9");
        // Held single request
        step(1'b0, 8'b0000_0100, "R3");
        step(1'b0, 8'b0000_0100, "R6");
        step(1'b0, 8'b1000_0000, "R6");
        step(1'b0, 8'b1111_1111, "R6");
        step(1'b0, '0, "R6");
        step(1'b0, '0, "R7");
        // Reset, then one-cycle pulse
        step(1'b1, '0, "R7");
        step(1'b0, '0, "R9");
        step(1'b0, 8'b0100_0000, "R4");
        step(1'b0, '0, "R4");
        step(1'b0, 8'b0000_0001, "R6");
        // Simultaneous arrivals
        step(1'b1, '0, "R1");
        step(1'b0, 8'b0010_1001, "R5");
        step(1'b0, 8'b1000_0000, "R6");
        step(1'b1, '0, "R1");
        step(1'b0, 8'b1111_1111, "R5");
        // Index 0 alone
        step(1'b1, '0, "R1");
        step(1'b0, 8'b0000_0001, "R3");
        step(1'b0, 8'b0000_0010, "R6");
        // Requests coincident with reset
        step(1'b1, 8'b1111_1111, "R8");
        step(1'b1, 8'b0001_0000, "R8");
        step(1'b0, '0, "R8");
        step(1'b0, '0, "R9");
        step(1'b0, 8'b0001_0010, "R5");
        step(1'b0, '0, "R6");
        // Walk every single index
        for (int b = 0; b < N; b++) begin
            step(1'b1, '0, "R7");
            step(1'b0, N'(1) << b, "R3");
            step(1'b0, ~(N'(1) << b), "R6");
        end
        done = 1'b1;
        finish_run();
    end
endmodule